// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block watches a simple CPU core through a set of registers. A 64-bit cycle timer advances on every clock. Two 64-bit event counters each follow one event input chosen from a vector of 64. Each event input reports how many times its event happened in the current cycle, from 0 to 2, so an event seen in both pipes can add two. A single control word sets up both counters. Each counter has a 9-bit field in that word. The field picks the event, turns counting on for the supervisor rings (0 to 2) and for the user ring (3), and chooses between two modes. One mode adds the event's occurrence count. The other adds one for every cycle in which the event is active.

Software reaches the block through a small register port. The port carries a valid strobe, a write flag, a 32-bit index and 64-bit write data. A read returns its data one cycle after the request. To start a new measurement, software writes a value into a counter, usually zero.

Top module: `pmu_top`

## Requirements
- R1: The register at index 0x10 is a 64-bit cycle timer. It adds one on every clock edge. A write to it loads the write data instead of adding one.
- R2: The register at index 0x11 is the control word and holds 32 bits. A read returns those 32 bits with bits 63:32 as zero. Bits 15:0 configure the counter at index 0x12, and bits 31:16 configure the counter at index 0x13.
- R3: Within a control half, bits 5:0 choose the event input. With bit 8 clear, the counter adds that input's 2-bit occurrence count, which is 0, 1 or 2. Event e occupies bits 2e+1:2e of the event vector.
- R4: With bit 8 of a control half set, the counter adds exactly one in every cycle in which the chosen input is nonzero, and adds zero otherwise.
- R5: Bit 6 of a control half enables counting while the privilege input is 0, 1 or 2. Bit 7 enables counting while it is 3. When the enable for the current ring is clear, the counter holds its value.
- R6: Event selects 0x10, 0x11, 0x20 and 0x21 are reserved. A counter set to one of them never changes except by a write.
- R7: A write to index 0x12 or 0x13 loads the full 64-bit write data. If an increment falls in the same cycle, the write wins.
- R8: A read (valid high, write low) places the addressed register's value from before that edge on the read data one cycle later. A read of any other 32-bit index returns zero. Reset clears every register and the read data.
- R9: The cycle timer and the event counters wrap from all-ones to zero with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | Register access request |
| accWrite | input | 1 | 1 = write, 0 = read |
| accIndex | input | 32 | Register index |
| accWdata | input | 64 | Write data |
| accRdata | output | 64 | Read data, valid the cycle after a read |
| evtCount | input | 128 | 64 event inputs, 2 bits each |
| curRing | input | 2 | Current privilege ring |

## Verification
The sweep runs every event select in both modes. In each run the two counters get different ring enables, and the event inputs and ring follow a pattern. This would expose a wrong event mux slice, a mode bit that adds the raw count in cycle mode, a swapped ring enable, or a reserved code that still counts. Writes are made while the chosen event is active. A design where the increment beat the write would read back one or two above the written value. Loads just below all-ones must read back zero two cycles later, which a saturating counter would fail. The reads cover unmapped indices that differ from a real index only in the upper bits, which would expose a decoder that compares too few bits. They also cover the upper half of the control word, which would expose a register stored as 64 bits.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  localparam int unsigned NUM_CNT = 2;
  localparam int unsigned IDX_W   = 32;
  localparam int unsigned CTL_W   = 32;
  localparam int unsigned HALF_W  = CTL_W / NUM_CNT;
  localparam int unsigned CFG_W   = 9;
  localparam int unsigned RING_LO_BIT = 6;
  localparam int unsigned RING_HI_BIT = 7;
  localparam int unsigned MODE_BIT    = 8;

  localparam logic [IDX_W-1:0] IDX_CYCLE = 32'h10;
  localparam logic [IDX_W-1:0] IDX_CTL   = 32'h11;
  localparam logic [IDX_W-1:0] IDX_EVT0  = 32'h12;
  localparam logic [IDX_W-1:0] IDX_EVT1  = 32'h13;

  typedef enum logic [2:0] {
    RD_NONE, RD_CYCLE, RD_CTL, RD_EVT0, RD_EVT1
  } rdSel_e;

  typedef struct packed {
    logic               wrCycle;
    logic               wrCtl;
    logic [NUM_CNT-1:0] wrEvt;
    logic               rdEn;
    rdSel_e             rdSel;
  } pmuStrobe_t;

  function automatic logic isReserved(input logic [5:0] sel);
    return (sel == 6'h10) || (sel == 6'h11) || (sel == 6'h20) || (sel == 6'h21);
  endfunction
endpackage

// File: rtl/pmu_ctrl.sv
`timescale 1ns/1ps
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [IDX_W-1:0] accIndex,
  output pmuStrobe_t       strobe
);
  logic hitCycle, hitCtl, hitEvt0, hitEvt1, doWr, doRd;

  always_comb begin
    hitCycle = (accIndex == IDX_CYCLE);
    hitCtl   = (accIndex == IDX_CTL);
    hitEvt0  = (accIndex == IDX_EVT0);
    hitEvt1  = (accIndex == IDX_EVT1);
    doWr     = accValid && accWrite;
    doRd     = accValid && !accWrite;

    strobe.wrCycle  = doWr && hitCycle;
    strobe.wrCtl    = doWr && hitCtl;
    strobe.wrEvt[0] = doWr && hitEvt0;
    strobe.wrEvt[1] = doWr && hitEvt1;
    strobe.rdEn     = doRd;
    if (hitCycle)     strobe.rdSel = RD_CYCLE;
    else if (hitCtl)  strobe.rdSel = RD_CTL;
    else if (hitEvt0) strobe.rdSel = RD_EVT0;
    else if (hitEvt1) strobe.rdSel = RD_EVT1;
    else              strobe.rdSel = RD_NONE;
  end
endmodule

// File: rtl/pmu_evt_counter.sv
`timescale 1ns/1ps
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 64,
  parameter int unsigned EVT_W      = 2,
  parameter int unsigned DATA_W     = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CFG_W-1:0]             cfg,
  input  logic [NUM_EVENTS*EVT_W-1:0]  evtCount,
  input  logic [1:0]                   curRing,
  input  logic                         wrEn,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            count
);
  localparam int unsigned SEL_W = $clog2(NUM_EVENTS);

  logic [SEL_W-1:0]  sel;
  logic [EVT_W-1:0]  selCount;
  logic              ringOk;
  logic              blocked;
  logic [DATA_W-1:0] incr;

  always_comb begin
    sel      = cfg[SEL_W-1:0];
    selCount = evtCount[int'(sel)*EVT_W +: EVT_W];
    ringOk   = (curRing == 2'd3) ? cfg[RING_HI_BIT] : cfg[RING_LO_BIT];
    blocked  = !ringOk || isReserved(6'(sel));
    if (blocked)            incr = '0;
    else if (cfg[MODE_BIT]) incr = DATA_W'(selCount != '0);
    else                    incr = DATA_W'(selCount);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (wrEn) count <= wrData;
    else           count <= count + incr;
  end
endmodule

// File: rtl/pmu_datapath.sv
`timescale 1ns/1ps
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 64,
  parameter int unsigned EVT_W      = 2,
  parameter int unsigned DATA_W     = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  pmuStrobe_t                  strobe,
  input  logic [DATA_W-1:0]           accWdata,
  input  logic [NUM_EVENTS*EVT_W-1:0] evtCount,
  input  logic [1:0]                  curRing,
  output logic [DATA_W-1:0]           accRdata,
  output logic [DATA_W-1:0]           cycleCnt,
  output logic [CTL_W-1:0]            ctlWord,
  output logic [DATA_W-1:0]           evCntA,
  output logic [DATA_W-1:0]           evCntB
);
  logic [DATA_W-1:0] evCnt [NUM_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cycleCnt <= '0;
    else if (strobe.wrCycle) cycleCnt <= accWdata;
    else                     cycleCnt <= cycleCnt + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctlWord <= '0;
    else if (strobe.wrCtl) ctlWord <= accWdata[CTL_W-1:0];
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    pmu_evt_counter #(
      .NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W), .DATA_W(DATA_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (ctlWord[k*HALF_W +: CFG_W]),
      .evtCount (evtCount),
      .curRing  (curRing),
      .wrEn     (strobe.wrEvt[k]),
      .wrData   (accWdata),
      .count    (evCnt[k])
    );
  end

  assign evCntA = evCnt[0];
  assign evCntB = evCnt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accRdata <= '0;
    else if (strobe.rdEn) begin
      case (strobe.rdSel)
        RD_CYCLE: accRdata <= cycleCnt;
        RD_CTL:   accRdata <= DATA_W'(ctlWord);
        RD_EVT0:  accRdata <= evCnt[0];
        RD_EVT1:  accRdata <= evCnt[1];
        default:  accRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pmu_top.sv
`timescale 1ns/1ps
module pmu_top
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 64,
  parameter int unsigned EVT_W      = 2,
  parameter int unsigned DATA_W     = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accValid,
  input  logic                        accWrite,
  input  logic [IDX_W-1:0]            accIndex,
  input  logic [DATA_W-1:0]           accWdata,
  output logic [DATA_W-1:0]           accRdata,
  input  logic [NUM_EVENTS*EVT_W-1:0] evtCount,
  input  logic [1:0]                  curRing
);
  pmuStrobe_t        strobe;
  logic [DATA_W-1:0] cycleCnt;
  logic [CTL_W-1:0]  ctlWord;
  logic [DATA_W-1:0] evCntA;
  logic [DATA_W-1:0] evCntB;

  pmu_ctrl u_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .accIndex (accIndex),
    .strobe   (strobe)
  );

  pmu_datapath #(
    .NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .accWdata (accWdata),
    .evtCount (evtCount),
    .curRing  (curRing),
    .accRdata (accRdata),
    .cycleCnt (cycleCnt),
    .ctlWord  (ctlWord),
    .evCntA   (evCntA),
    .evCntB   (evCntB)
  );
endmodule

// File: rtl/pmu_checker.sv
`timescale 1ns/1ps
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accValid,
  input logic              accWrite,
  input logic [IDX_W-1:0]  accIndex,
  input logic [DATA_W-1:0] accWdata,
  input logic [DATA_W-1:0] accRdata,
  input logic [DATA_W-1:0] cycleCnt,
  input logic [CTL_W-1:0]  ctlWord,
  input logic [DATA_W-1:0] evCntA
);
  logic wrCyc, wrCtl, wrA, rdUnmapped;
  assign wrCyc = accValid && accWrite && (accIndex == IDX_CYCLE);
  assign wrCtl = accValid && accWrite && (accIndex == IDX_CTL);
  assign wrA   = accValid && accWrite && (accIndex == IDX_EVT0);
  assign rdUnmapped = accValid && !accWrite && (accIndex != IDX_CYCLE) &&
                      (accIndex != IDX_CTL) && (accIndex != IDX_EVT0) && (accIndex != IDX_EVT1);

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrCyc |=> cycleCnt == $past(cycleCnt) + DATA_W'(1)); // R1
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrCtl |=> ctlWord == $past(accWdata[CTL_W-1:0])); // R2
  AST_CYCLE_MODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWord[MODE_BIT] && !wrA) |=> (evCntA - $past(evCntA)) <= DATA_W'(1)); // R4
  AST_RINGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWord[RING_HI_BIT:RING_LO_BIT] == 2'b00 && !wrA) |=> $stable(evCntA)); // R5
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (isReserved(ctlWord[5:0]) && !wrA) |=> $stable(evCntA)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wrA |=> evCntA == $past(accWdata)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdUnmapped |=> accRdata == '0); // R8
endmodule

bind pmu_top pmu_checker #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .accValid (accValid),
  .accWrite (accWrite),
  .accIndex (accIndex),
  .accWdata (accWdata),
  .accRdata (accRdata),
  .cycleCnt (cycleCnt),
  .ctlWord  (ctlWord),
  .evCntA   (evCntA)
);

// File: tb/pmu_top_tb.sv
`timescale 1ns/1ps
module pmu_top_tb_top;
  localparam int NE = 64;
  localparam int EW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          accValid = 1'b0;
  logic          accWrite = 1'b0;
  logic [31:0]   accIndex = '0;
  logic [63:0]   accWdata = '0;
  logic [63:0]   accRdata;
  logic [NE*EW-1:0] evtCount = '0;
  logic [1:0]    curRing = 2'd0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pmu_top dut_i (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accWrite(accWrite),
    .accIndex(accIndex), .accWdata(accWdata), .accRdata(accRdata),
    .evtCount(evtCount), .curRing(curRing)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Each task is entered just after a falling edge and returns one cycle later.
  task automatic doWrite(input logic [31:0] idx, input logic [63:0] d);
    accValid = 1'b1; accWrite = 1'b1; accIndex = idx; accWdata = d;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  task automatic doRead(input logic [31:0] idx, output logic [63:0] d);
    accValid = 1'b1; accWrite = 1'b0; accIndex = idx;
    @(negedge clk);
    accValid = 1'b0;
    d = accRdata;
  endtask

  function automatic int patVal(input int e, input int i);
    return (e * 7 + i * 5) % 3;
  endfunction

  function automatic bit isRsv(input int s);
    return (s == 16) || (s == 17) || (s == 32) || (s == 33);
  endfunction

  function automatic longint expectCnt(input int sel, input int en, input int mode);
    longint acc = 0;
    for (int i = 0; i < 8; i++) begin
      int ring = i % 4;
      int c = patVal(sel, i);
      bit ok = (ring == 3) ? en[1] : en[0];
      if (ok && !isRsv(sel)) acc += (mode != 0) ? ((c != 0) ? 1 : 0) : c;
    end
    return acc;
  endfunction

  initial begin
    logic [63:0] rd;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset read data", accRdata, 64'h0);
    doRead(32'h11, rd); check("R8 reset ctl", rd, 64'h0);
    doRead(32'h12, rd); check("R8 reset cnt0", rd, 64'h0);
    doRead(32'h13, rd); check("R8 reset cnt1", rd, 64'h0);

    // R1 cycle timer counts every edge after a load
    doWrite(32'h10, 64'd0);
    repeat (5) @(negedge clk);
    doRead(32'h10, rd); check("R1 cycle count", rd, 64'd5);
    doWrite(32'h10, 64'd1000);
    doRead(32'h10, rd); check("R1 cycle load", rd, 64'd1000);
    // R9 wrap of cycle timer
    doWrite(32'h10, '1);
    doRead(32'h10, rd); check("R9 cycle at all-ones", rd, '1);
    doRead(32'h10, rd); check("R9 cycle wrapped", rd, 64'd0);

    // R2 upper control bits read as zero
    doWrite(32'h11, '1);
    doRead(32'h11, rd); check("R2 ctl high zero", rd, 64'h0000_0000_FFFF_FFFF);
    // R8 unmapped indices return zero even after a nonzero read
    doRead(32'h11, rd);
    doRead(32'h14, rd);        check("R8 unmapped 0x14", rd, 64'h0);
    doRead(32'h11, rd);
    doRead(32'h8000_0012, rd); check("R8 unmapped high bits", rd, 64'h0);
    doRead(32'h0F, rd);        check("R8 unmapped 0x0F", rd, 64'h0);

    // R7 write beats increment; R9 event counter wrap
    doWrite(32'h11, 64'h0000_0000_0000_00C5); // event 5, both rings, occurrence mode
    evtCount = '0; evtCount[5*EW +: EW] = 2'd2; curRing = 2'd0;
    doWrite(32'h12, 64'd100);
    doRead(32'h12, rd); check("R7 write wins", rd, 64'd100);
    doRead(32'h12, rd); check("R3 add two", rd, 64'd102);
    doWrite(32'h12, 64'hFFFF_FFFF_FFFF_FFFE);
    doRead(32'h12, rd); check("R7 write wins near top", rd, 64'hFFFF_FFFF_FFFF_FFFE);
    doRead(32'h12, rd); check("R9 counter wrapped", rd, 64'd0);
    evtCount = '0;

    // Sweep of every select, both modes, all ring-enable pairs
    for (int sel = 0; sel < 64; sel++) begin
      for (int mode = 0; mode < 2; mode++) begin
        int enA = sel % 4;
        int enB = (sel + 1) % 4;
        int selB = 63 - sel;
        int modeB = 1 - mode;
        logic [15:0] hA = 16'(sel | (enA << 6) | (mode << 8));
        logic [15:0] hB = 16'(selB | (enB << 6) | (modeB << 8));
        logic [63:0] gotA, gotB;
        doWrite(32'h11, {32'h0, hB, hA});
        doWrite(32'h12, 64'd0);
        doWrite(32'h13, 64'd0);
        for (int i = 0; i < 8; i++) begin
          for (int e = 0; e < NE; e++) evtCount[e*EW +: EW] = 2'(patVal(e, i));
          curRing = 2'(i % 4);
          @(negedge clk);
        end
        evtCount = '0; curRing = 2'd0;
        doRead(32'h12, gotA);
        doRead(32'h13, gotB);
        // R3 R4 R5 R6: select, mode, ring filter and reserved codes
        check($sformatf("R3/R4/R5/R6 cnt0 sel=%0d mode=%0d", sel, mode), gotA,
              64'(expectCnt(sel, enA, mode)));
        check($sformatf("R2 cnt1 upper half sel=%0d mode=%0d", selB, modeB), gotB,
              64'(expectCnt(selB, enB, modeB)));
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule